// File: doc/BRIEF.md
# Two's-Complement Ripple Adder with Sign-Corrected Top Bit

This block adds two operands whose widths may differ and returns a result one bit wider than the wider operand, so the sum can never overflow. It is purely combinational. The result changes whenever an operand changes, with no clock, latency or handshake. The carry chain starts with a half adder at bit 0, so there is no carry input. Each higher position uses a full adder that takes the carry from the position below it.

The parameter `SIGNED` selects how the operands are read and how the extra bit is formed. With `SIGNED = 1`, both operands are two's complement. The narrower one is sign-extended, and the extra bit is set to the XOR of both extended operand MSBs and the final carry. The full result is then the exact signed sum. With `SIGNED = 0`, the narrower operand is zero-extended and the extra bit is the raw carry out of the top position.

Top module: `srca_top`

## Requirements
- R1: The result `sum_o` is N+1 bits wide, where N is the larger of `A_W` and `B_W`.
- R2: The narrower operand is widened to N bits before adding: by replicating its MSB when `SIGNED = 1`, and by padding with zeros when `SIGNED = 0`.
- R3: Bit 0 of the chain is a half adder with no carry input, and positions 1 to N-1 are full adders fed by the carry of the position below. So `sum_o[N-1:0]` equals the widened operands summed modulo 2^N, and zero operands give a zero result.
- R4: With `SIGNED = 0`, `sum_o[N]` is the carry out of position N-1, and `sum_o` read as unsigned equals the unsigned sum of the zero-extended operands.
- R5: With `SIGNED = 1`, `sum_o[N]` equals the widened `a[N-1]` XOR the widened `b[N-1]` XOR the carry out of position N-1. So `sum_o` read as an (N+1)-bit two's-complement value equals the exact signed sum.
- R6: With N = 1, the single half adder alone drives bit 0 (its sum) and bit 1 (its carry). The sign correction of R5 still applies when `SIGNED = 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | A_W | First operand |
| op_b | input | B_W | Second operand |
| sum_o | output | max(A_W,B_W)+1 | Sum, top bit sign-corrected or raw carry depending on SIGNED |

## Verification
The bench builds five copies of the adder:
- signed with widths 4 and 3;
- unsigned with widths 3 and 4;
- signed and unsigned with both widths 1;
- signed with both widths 5.

Each copy is swept over every operand pair. The unequal-width copies exercise both sign and zero extension, with the narrower operand on either port. The width-1 copies reach the half-adder-only chain. The 5-bit copy covers the most-negative plus most-negative case, where only the corrected top bit gives the right sign.

// File: rtl/srca_pkg.sv
package srca_pkg;
  function automatic int wider(input int x, input int y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/srca_widen.sv
module srca_widen #(
  parameter int IN_W   = 4,
  parameter int OUT_W  = 8,
  parameter bit SIGNED = 1'b1
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W == 0) begin : g_same
      assign dout = din;
    end else if (SIGNED) begin : g_sext
      assign dout = {{PAD_W{din[IN_W-1]}}, din};
    end else begin : g_zext
      assign dout = {{PAD_W{1'b0}}, din};
    end
  endgenerate
endmodule

// File: rtl/srca_half_cell.sv
module srca_half_cell (
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  assign s  = a ^ b;
  assign co = a & b;

  always_comb begin
    if (!$isunknown({a, b}))
      AST_HALF_CELL_COUNT: assert ({co, s} == (2'(a) + 2'(b))); // R3
  end
endmodule

// File: rtl/srca_full_cell.sv
module srca_full_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p;
  assign p  = a ^ b;
  assign s  = p ^ ci;
  assign co = (a & b) | (p & ci);

  always_comb begin
    if (!$isunknown({a, b, ci}))
      AST_FULL_CELL_COUNT: assert ({co, s} == (2'(a) + 2'(b) + 2'(ci))); // R3
  end
endmodule

// File: rtl/srca_top_bit.sv
module srca_top_bit #(
  parameter bit SIGNED = 1'b1
) (
  input  logic msb_a,
  input  logic msb_b,
  input  logic carry,
  output logic top
);
  generate
    if (SIGNED) begin : g_fix
      assign top = msb_a ^ msb_b ^ carry;
    end else begin : g_raw
      assign top = carry;
    end
  endgenerate
endmodule

// File: rtl/srca_top.sv
module srca_top #(
  parameter int A_W    = 8,
  parameter int B_W    = 8,
  parameter bit SIGNED = 1'b1,
  localparam int N     = srca_pkg::wider(A_W, B_W)
) (
  input  logic [A_W-1:0] op_a,
  input  logic [B_W-1:0] op_b,
  output logic [N:0]     sum_o
);
  logic [N-1:0] ext_a;
  logic [N-1:0] ext_b;
  logic [N-1:0] cy;

  srca_widen #(.IN_W(A_W), .OUT_W(N), .SIGNED(SIGNED)) u_wa (.din(op_a), .dout(ext_a));
  srca_widen #(.IN_W(B_W), .OUT_W(N), .SIGNED(SIGNED)) u_wb (.din(op_b), .dout(ext_b));

  generate
    for (genvar i = 0; i < N; i++) begin : g_chain
      if (i == 0) begin : g_ha
        srca_half_cell u_ha (.a(ext_a[0]), .b(ext_b[0]), .s(sum_o[0]), .co(cy[0]));
      end else begin : g_fa
        srca_full_cell u_fa (.a(ext_a[i]), .b(ext_b[i]), .ci(cy[i-1]),
                             .s(sum_o[i]), .co(cy[i]));
      end
    end
  endgenerate

  srca_top_bit #(.SIGNED(SIGNED)) u_top (
    .msb_a(ext_a[N-1]), .msb_b(ext_b[N-1]), .carry(cy[N-1]), .top(sum_o[N])
  );

  generate
    if (SIGNED) begin : g_chk_s
      always_comb begin
        if (!$isunknown({op_a, op_b, sum_o})) begin
          AST_SIGNED_EXACT: assert ($signed(sum_o) ==
            ($signed({ext_a[N-1], ext_a}) + $signed({ext_b[N-1], ext_b}))); // R5
          AST_SEXT_A: assert (ext_a[N-1:A_W-1] == {(N-A_W+1){op_a[A_W-1]}}); // R2
        end
      end
    end else begin : g_chk_u
      always_comb begin
        if (!$isunknown({op_a, op_b, sum_o})) begin
          AST_UNSIGNED_EXACT: assert (sum_o ==
            ((N+1)'(op_a) + (N+1)'(op_b))); // R4
        end
      end
    end
  endgenerate

  always_comb begin
    if (!$isunknown({op_a, op_b, sum_o}))
      AST_LOW_BITS_MOD: assert (sum_o[N-1:0] == N'(ext_a + ext_b)); // R3
  end
endmodule

// File: tb/srca_top_tb.sv
module srca_top_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [3:0] a0; logic [2:0] b0; logic [4:0] s0;
  logic [2:0] a1; logic [3:0] b1; logic [4:0] s1;
  logic [0:0] a2, b2;             logic [1:0] s2;
  logic [0:0] a3, b3;             logic [1:0] s3;
  logic [4:0] a4, b4;             logic [5:0] s4;

  srca_top #(.A_W(4), .B_W(3), .SIGNED(1'b1)) u_dut    (.op_a(a0), .op_b(b0), .sum_o(s0));
  srca_top #(.A_W(3), .B_W(4), .SIGNED(1'b0)) u_dut_u  (.op_a(a1), .op_b(b1), .sum_o(s1));
  srca_top #(.A_W(1), .B_W(1), .SIGNED(1'b1)) u_dut_s1 (.op_a(a2), .op_b(b2), .sum_o(s2));
  srca_top #(.A_W(1), .B_W(1), .SIGNED(1'b0)) u_dut_u1 (.op_a(a3), .op_b(b3), .sum_o(s3));
  srca_top #(.A_W(5), .B_W(5), .SIGNED(1'b1)) u_dut_s5 (.op_a(a4), .op_b(b4), .sum_o(s4));

  function automatic int as_int(input int v, input int w, input bit sgn);
    int m;
    m = v & ((1 << w) - 1);
    if (sgn && m[w-1]) m = m - (1 << w);
    return m;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  initial begin
    a0 = '0; b0 = '0; a1 = '0; b1 = '0; a2 = '0; b2 = '0; a3 = '0; b3 = '0; a4 = '0; b4 = '0;
    @(negedge clk);
    // R1: result widths
    check("R1 width s0", $bits(s0), 5);
    check("R1 width s1", $bits(s1), 5);
    check("R1 width s4", $bits(s4), 6);
    // R3: zero inputs give zero, no carry-in leak
    check("R3 zero s0", int'(s0), 0);
    check("R3 zero s4", int'(s4), 0);

    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 8; y++) begin
        @(posedge clk); a0 = 4'(x); b0 = 3'(y); a1 = 3'(y); b1 = 4'(x);
        @(negedge clk);
        // R2 R5: sign extension of the 3-bit operand, exact signed sum
        check("R5 R2 signed 4+3", as_int(int'(s0), 5, 1'b1), as_int(x, 4, 1'b1) + as_int(y, 3, 1'b1));
        // R2 R4: zero extension, raw carry
        check("R4 R2 unsigned 3+4", int'(s1), x + y);
        check("R4 carry bit", int'(s1[4]), ((x + y) >> 4) & 1);
      end
    end

    for (int x = 0; x < 2; x++) begin
      for (int y = 0; y < 2; y++) begin
        @(posedge clk); a2 = 1'(x); b2 = 1'(y); a3 = 1'(x); b3 = 1'(y);
        @(negedge clk);
        check("R6 signed N=1", as_int(int'(s2), 2, 1'b1), as_int(x, 1, 1'b1) + as_int(y, 1, 1'b1));
        check("R6 unsigned N=1", int'(s3), x + y);
      end
    end

    for (int x = 0; x < 32; x++) begin
      for (int y = 0; y < 32; y++) begin
        @(posedge clk); a4 = 5'(x); b4 = 5'(y);
        @(negedge clk);
        check("R5 signed 5+5", as_int(int'(s4), 6, 1'b1), as_int(x, 5, 1'b1) + as_int(y, 5, 1'b1));
        check("R3 low bits", int'(s4[4:0]), (x + y) & 31);
      end
    end

    @(posedge clk); a4 = 5'b10000; b4 = 5'b10000;
    @(negedge clk);
    check("R5 most negative pair", int'(s4), 6'b100000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule